// File: doc/BRIEF.md
# Ethernet MAC DMA Control Register Bank

This block is the software-visible register file of a small Ethernet MAC with descriptor-based DMA. It stores the CAM filter controls and sixteen CAM address pairs, the transmit and receive descriptor list bases, the command word, FIFO and frame-length limits, the interrupt enable and interrupt status words, and the current-descriptor pointers. It is accessed through a single-cycle word-indexed port: writes commit on the clock edge and reads are combinational.

The DMA engines sit outside the block. They report events through a 32-bit vector of one-cycle set pulses, which lands in the interrupt status word. Software clears status with write-one-to-clear. Two interrupt lines, one for transmit and one for receive, are driven from the enabled status bits. The command word holds a self-clearing soft reset. For a fixed number of cycles the bank reads as all zeros and ignores traffic. It then comes back with every register at its power-on value and every CAM entry cleared.

Top module: `emc_regbank`

## Requirements
- R1: After power-on reset the following indices read the listed values: 0x22 and 0x23 read 0xFFFFFFFC, 0x26 reads 0x00900000, 0x27 reads 0x00000101, 0x2A reads 0x00000800 and 0x2E reads 0x00007FFF. Every other index from 0x00 to 0x36 reads 0.
- R2: The layout is fixed. Index 0 is CAM command and index 1 is CAM enable. CAM pair n sits at indices 2+2n (high word) and 3+2n (low word). From 0x22 the registers run in order: TX list base, RX list base, command (0x24), MII data, MII address, FIFO threshold, TX poll, RX poll, max frame, interrupt enable (0x2B), interrupt status (0x2C), general status, missed count, three packet counters, max-frame status, current TX descriptor, current TX buffer, current RX descriptor, current RX buffer (0x36). Every register other than interrupt status stores the written word and reads it back. Indices 0x37 to 0x3F read 0 and ignore writes.
- R3: Writing the interrupt status word (0x2C) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A set pulse on intSet sets the status bit of the same position only for the implemented bits 24, 23, 18, 16, 11, 10, 9, 8, 4, 3 and 0. The other status bits always read 0.
- R5: When a set pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: txIrq is high exactly when some status bit in 31:16 is set and the same bit of the interrupt enable word (0x2B) is set.
- R7: rxIrq is high exactly when some status bit in 15:0 is set and the same enable bit is set.
- R8: Writing the command word with bit 24 set starts a soft reset lasting 16 cycles. Every read returns 0 during that time.
- R9: When the soft reset ends, every register holds its R1 value, the CAM pairs and CAM controls read 0, and command bit 24 reads 0.
- R10: Bus writes and status set pulses that arrive while a soft reset is in progress have no effect.
- R11: The control outputs follow the stored words. txOn is command bit 8, rxOn is command bit 0, longPktOk is command bit 1, camAcceptUni is CAM command bit 0, and camCompareEn is CAM command bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, commits on the clock edge |
| busAddr | input | 6 | Word index for read and write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data |
| intSet | input | 32 | One-cycle status set pulses from the DMA engines |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt |
| txOn | output | 1 | Transmit enable from the command word |
| rxOn | output | 1 | Receive enable from the command word |
| longPktOk | output | 1 | Long-packet acceptance from the command word |
| camAcceptUni | output | 1 | Accept unicast from the CAM command word |
| camCompareEn | output | 1 | CAM compare enable from the CAM command word |

## Verification
The bench walks all 32 status positions. For each one it checks that a pulse sets only an implemented bit, that the bit raises the correct interrupt line only when enabled, and that a write-one clears it. A design with a wrong mask, a wrong split between the two lines or inverted clear polarity fails there. The soft reset is timed by reading a non-zero default on every cycle. A sequencer that is off by one cycle, or a read path that leaks data while busy, gives a wrong value in the first or last window cycle. A write and a set pulse are also issued inside the window, so a design that lets traffic through during the reset keeps that state. The set-versus-clear collision and the reads beyond the last index catch a wrong priority and address aliasing.

// File: rtl/emc_regs_pkg.sv
package emc_regs_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 6;
  localparam int CAM_PAIRS = 16;

  localparam int IX_CAMCMD  = 0;
  localparam int IX_CAMEN   = 1;
  localparam int IX_CAMBASE = 2;
  localparam int IX_TXBASE  = IX_CAMBASE + 2 * CAM_PAIRS;
  localparam int IX_RXBASE  = IX_TXBASE + 1;
  localparam int IX_CMD     = IX_TXBASE + 2;
  localparam int IX_MIIADR  = IX_TXBASE + 4;
  localparam int IX_FIFOTH  = IX_TXBASE + 5;
  localparam int IX_MAXFRM  = IX_TXBASE + 8;
  localparam int IX_INTEN   = IX_TXBASE + 9;
  localparam int IX_ISTAT   = IX_TXBASE + 10;
  localparam int IX_MISSCNT = IX_TXBASE + 12;
  localparam int NUM_REGS   = IX_TXBASE + 21;

  localparam int CMD_SWR_BIT  = 24;
  localparam int CMD_TXON_BIT = 8;
  localparam int CMD_LONG_BIT = 1;
  localparam int CMD_RXON_BIT = 0;
  localparam int CAM_UNI_BIT  = 0;
  localparam int CAM_CMP_BIT  = 4;

  localparam logic [REG_W-1:0] INT_MASK = 32'h0185_0F19;

  typedef struct packed {
    logic busy;
    logic loadDefaults;
    logic wrValid;
  } regStrobe_t;

  function automatic logic [REG_W-1:0] regDefault(input int idx);
    logic [REG_W-1:0] v;
    v = '0;
    if (idx == IX_TXBASE || idx == IX_RXBASE) v = 32'hFFFF_FFFC;
    if (idx == IX_MIIADR)  v = 32'h0090_0000;
    if (idx == IX_FIFOTH)  v = 32'h0000_0101;
    if (idx == IX_MAXFRM)  v = 32'h0000_0800;
    if (idx == IX_MISSCNT) v = 32'h0000_7FFF;
    return v;
  endfunction
endpackage

// File: rtl/emc_reg_ctrl.sv
module emc_reg_ctrl
  import emc_regs_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output regStrobe_t        stb
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] rstCnt;
  logic             busy;
  logic             swrReq;
  logic             inRange;

  assign busy    = (rstCnt != '0);
  assign inRange = (int'(busAddr) < NUM_REGS);
  assign swrReq  = busWrEn && !busy && (int'(busAddr) == IX_CMD) && busWrData[CMD_SWR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (swrReq) begin
      rstCnt <= CNT_W'(RST_CYCLES);
    end else if (busy) begin
      rstCnt <= rstCnt - 1'b1;
    end
  end

  always_comb begin
    stb.busy         = busy;
    stb.loadDefaults = swrReq;
    stb.wrValid      = busWrEn && !busy && !swrReq && inRange;
  end
endmodule

// File: rtl/emc_reg_dp.sv
module emc_reg_dp
  import emc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  input  logic [REG_W-1:0]  intSet,
  output logic [REG_W-1:0]  busRdData,
  output logic [REG_W-1:0]  intStatQ,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              txOn,
  output logic              rxOn,
  output logic              longPktOk,
  output logic              camAcceptUni,
  output logic              camCompareEn
);
  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] regQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [REG_W-1:0] RV = regDefault(i);
    logic hit;
    assign hit = stb.wrValid && (int'(busAddr) == i);

    if (i == IX_ISTAT) begin : g_w1c
      logic [REG_W-1:0] clrMask;
      logic [REG_W-1:0] setMask;
      assign clrMask = hit ? busWrData : '0;
      assign setMask = stb.busy ? '0 : intSet;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 regQ[i] <= RV;
        else if (stb.loadDefaults) regQ[i] <= RV;
        else                       regQ[i] <= ((regQ[i] & ~clrMask) | setMask) & INT_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 regQ[i] <= RV;
        else if (stb.loadDefaults) regQ[i] <= RV;
        else if (hit)              regQ[i] <= busWrData;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (!stb.busy && int'(busAddr) < NUM_REGS) busRdData = regQ[busAddr];
  end

  assign intStatQ     = regQ[IX_ISTAT];
  assign txIrq        = |(regQ[IX_ISTAT][REG_W-1:HALF] & regQ[IX_INTEN][REG_W-1:HALF]);
  assign rxIrq        = |(regQ[IX_ISTAT][HALF-1:0] & regQ[IX_INTEN][HALF-1:0]);
  assign txOn         = regQ[IX_CMD][CMD_TXON_BIT];
  assign rxOn         = regQ[IX_CMD][CMD_RXON_BIT];
  assign longPktOk    = regQ[IX_CMD][CMD_LONG_BIT];
  assign camAcceptUni = regQ[IX_CAMCMD][CAM_UNI_BIT];
  assign camCompareEn = regQ[IX_CAMCMD][CAM_CMP_BIT];
endmodule

// File: rtl/emc_regbank.sv
module emc_regbank
  import emc_regs_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [31:0] intSet,
  output logic        txIrq,
  output logic        rxIrq,
  output logic        txOn,
  output logic        rxOn,
  output logic        longPktOk,
  output logic        camAcceptUni,
  output logic        camCompareEn
);
  regStrobe_t       stb;
  logic [REG_W-1:0] intStatQ;

  emc_reg_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .stb(stb)
  );

  emc_reg_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr),
    .busWrData(busWrData), .intSet(intSet), .busRdData(busRdData),
    .intStatQ(intStatQ), .txIrq(txIrq), .rxIrq(rxIrq), .txOn(txOn),
    .rxOn(rxOn), .longPktOk(longPktOk), .camAcceptUni(camAcceptUni),
    .camCompareEn(camCompareEn)
  );
endmodule

// File: rtl/emc_regbank_chk.sv
module emc_regbank_chk
  import emc_regs_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [REG_W-1:0]  busWrData,
  input logic [REG_W-1:0]  busRdData,
  input logic [REG_W-1:0]  intSet,
  input logic [REG_W-1:0]  intStatQ,
  input logic              txIrq,
  input regStrobe_t        stb
);
  logic [15:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busyLen <= '0;
    else if (stb.busy) busyLen <= busyLen + 1'b1;
    else               busyLen <= '0;
  end

  // R8: reads give zero while the soft reset runs
  p_busy_reads_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.busy |-> busRdData == '0);

  // R8: a soft reset request starts the busy window
  p_swr_starts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !stb.busy && int'(busAddr) == IX_CMD && busWrData[CMD_SWR_BIT]) |=> stb.busy);

  // R8: the window is exactly RST_CYCLES long
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.busy && $past(stb.busy)) |-> busyLen == 16'(RST_CYCLES));

  // R9: on leaving reset the addressed register shows its default
  p_defaults_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.busy) |-> busRdData == regDefault(int'(busAddr)));

  // R5: an implemented set pulse outside reset always lands
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.busy && !stb.loadDefaults && (intSet & INT_MASK) != '0)
      |=> (intStatQ & $past(intSet & INT_MASK)) == $past(intSet & INT_MASK));

  // R4: unimplemented status bits stay clear
  p_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (intStatQ & ~INT_MASK) == '0);

  // R6: the transmit line rises only after a set pulse or a bus write
  p_tx_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrq) |-> ($past(busWrEn) || $past(intSet[REG_W-1:REG_W/2] != '0)));
endmodule

bind emc_regbank emc_regbank_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .intSet(intSet),
  .intStatQ(intStatQ), .txIrq(txIrq), .stb(stb)
);

// File: tb/emc_regbank_bench.sv
`timescale 1ns/1ps
module emc_regbank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] intSet = '0;
  logic        txIrq, rxIrq, txOn, rxOn, longPktOk, camAcceptUni, camCompareEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  localparam logic [31:0] IMPL = (32'd1 << 24) | (32'd1 << 23) | (32'd1 << 18) | (32'd1 << 16)
                               | (32'd1 << 11) | (32'd1 << 10) | (32'd1 << 9) | (32'd1 << 8)
                               | (32'd1 << 4) | (32'd1 << 3) | 32'd1;

  always #5 clk = ~clk;

  emc_regbank u_emc_regbank (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .intSet(intSet),
    .txIrq(txIrq), .rxIrq(rxIrq), .txOn(txOn), .rxOn(rxOn),
    .longPktOk(longPktOk), .camAcceptUni(camAcceptUni), .camCompareEn(camCompareEn)
  );

  function automatic logic [31:0] expDefault(input int idx);
    case (idx)
      8'h22, 8'h23: return 32'hFFFF_FFFC;
      8'h26:        return 32'h0090_0000;
      8'h27:        return 32'h0000_0101;
      8'h2A:        return 32'h0000_0800;
      8'h2E:        return 32'h0000_7FFF;
      default:      return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = 6'(a); busWrData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input int a, input logic [31:0] exp);
    busAddr = 6'(a);
    #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic pulse(input logic [31:0] m);
    intSet = m;
    tick();
    intSet = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 / R2: defaults, and out-of-range reads zero
    for (int a = 0; a < 64; a++) rd("R1 reset value", a, (a < 8'h37) ? expDefault(a) : 32'h0);

    // R2: store/read-back for every plain register
    for (int a = 0; a < 64; a++) begin
      if (a != 8'h24 && a != 8'h2C) wr(a, 32'h5A00_0000 ^ (32'(a) * 32'h0001_0203));
    end
    for (int a = 0; a < 64; a++) begin
      if (a != 8'h24 && a != 8'h2C)
        rd("R2 readback", a, (a < 8'h37) ? (32'h5A00_0000 ^ (32'(a) * 32'h0001_0203)) : 32'h0);
    end

    // R11: control bits
    wr(8'h24, 32'h0000_0103);
    wr(8'h00, 32'h0000_0011);
    chk("R11 txOn", 32'(txOn), 32'd1);
    chk("R11 rxOn", 32'(rxOn), 32'd1);
    chk("R11 longPktOk", 32'(longPktOk), 32'd1);
    chk("R11 camAcceptUni", 32'(camAcceptUni), 32'd1);
    chk("R11 camCompareEn", 32'(camCompareEn), 32'd1);
    wr(8'h24, 32'h0000_0002);
    wr(8'h00, 32'h0000_0010);
    chk("R11 txOn off", 32'(txOn), 32'd0);
    chk("R11 rxOn off", 32'(rxOn), 32'd0);
    chk("R11 camAcceptUni off", 32'(camAcceptUni), 32'd0);

    // R3 / R4 / R6 / R7: sweep of every status bit
    wr(8'h2C, 32'hFFFF_FFFF);
    for (int b = 0; b < 32; b++) begin
      logic [31:0] m;
      logic [31:0] e;
      m = 32'd1 << b;
      e = m & IMPL;
      wr(8'h2B, 32'h0);
      pulse(m);
      rd("R4 set pulse", 8'h2C, e);
      chk("R6 tx masked", 32'(txIrq), 32'd0);
      chk("R7 rx masked", 32'(rxIrq), 32'd0);
      wr(8'h2B, m);
      chk("R6 tx line", 32'(txIrq), 32'((e != 0) && (b >= 16)));
      chk("R7 rx line", 32'(rxIrq), 32'((e != 0) && (b < 16)));
      wr(8'h2C, ~m);
      rd("R3 zero keeps", 8'h2C, e);
      wr(8'h2C, m);
      rd("R3 one clears", 8'h2C, 32'h0);
    end

    // R3: partial clear with all set
    pulse(32'hFFFF_FFFF);
    wr(8'h2C, 32'h0000_0F00);
    rd("R3 partial clear", 8'h2C, IMPL & ~32'h0000_0F00);
    wr(8'h2C, 32'hFFFF_FFFF);

    // R5: set and clear collide
    pulse(32'h0004_0010);
    intSet = 32'h0000_0010;
    wr(8'h2C, 32'h0004_0010);
    intSet = '0;
    rd("R5 set beats clear", 8'h2C, 32'h0000_0010);
    wr(8'h2C, 32'hFFFF_FFFF);

    // R8 / R9: soft reset window, timed on a non-zero default
    wr(8'h27, 32'h0000_0303);
    wr(8'h05, 32'h1234_5678);
    wr(8'h2C - 1, 32'hFFFF_FFFF);
    pulse(32'h0000_0001);
    wr(8'h24, 32'h0100_0101);
    for (int k = 0; k < 16; k++) begin
      rd("R8 zero while busy", 8'h27, 32'h0);
      tick();
    end
    rd("R9 threshold default", 8'h27, 32'h0000_0101);
    for (int a = 0; a < 8'h37; a++) rd("R9 all defaults", a, expDefault(a));
    chk("R9 rxIrq cleared", 32'(rxIrq), 32'd0);
    chk("R9 txOn cleared", 32'(txOn), 32'd0);

    // R10: traffic during reset is dropped
    wr(8'h24, 32'h0100_0000);
    wr(8'h22, 32'h0000_1234);
    pulse(32'hFFFF_FFFF);
    wr(8'h24, 32'h0000_0100);
    repeat (20) tick();
    rd("R10 write dropped", 8'h22, 32'hFFFF_FFFC);
    rd("R10 pulse dropped", 8'h2C, 32'h0);
    rd("R10 cmd write dropped", 8'h24, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule